// File: doc/BRIEF.md
# DMA Channel Physical Address Generator

This block produces the physical memory address and keeps the transfer count for a single DMA channel while a transfer runs. A host loads a page value, a 16-bit starting offset, a 16-bit count and a width select into the channel. Each accepted transfer strobe then presents one physical byte address, advances the offset by one unit, and lowers the count by one. The channel raises a terminal-count pulse on its last transfer and stops until it is loaded again.

In byte mode the page value is placed above the offset, so each page spans 64K bytes. In word mode the offset counts 16-bit words. It is shifted up one bit under the upper page bits, so each page spans 128K bytes and the address is always even. The page value is never incremented. A transfer that runs off the end of its offset range wraps back to the start of the same page. A mask input freezes the channel without losing its state.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After a synchronous reset, valid_o, tc_o, active_o and word_o read 0, phys_addr_o reads 0 and byte_en_o reads 2'b00.
- R2: In byte mode (word_mode_i=0 at load), the presented address is {page[7:0], offset[15:0]}.
- R3: In word mode (word_mode_i=1 at load), the presented address is {page[7:1], offset[15:0], 1'b0}. Page bit 0 has no effect and address bit 0 is always 0.
- R4: Each accepted strobe advances the offset by exactly one. Offset 0xFFFF is followed by 0x0000 and the page bits stay unchanged.
- R5: A loaded count of N gives exactly N+1 accepted transfers. tc_o pulses together with valid_o on the last one (the count goes from 0x0000 to 0xFFFF). active_o is 0 from that cycle onward, and later strobes give no valid_o.
- R6: While mask_i is 1, a strobe produces no valid_o and leaves the offset and count unchanged. The next unmasked strobe presents the address that the masked strobe would have presented.
- R7: Outputs are registered. valid_o, phys_addr_o, byte_en_o, word_o and tc_o for a strobe sampled at a rising edge appear right after that edge and last one cycle. With no accepted strobe, valid_o and tc_o are 0.
- R8: byte_en_o is 2'b01 for an even byte-mode address, 2'b10 for an odd byte-mode address, and 2'b11 in word mode. word_o is 1 exactly for word-mode transfers.
- R9: load_i sets active_o and takes the new page, offset, count and mode. A strobe at the same edge as a load is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Arm the channel with the values below |
| page_i | input | 8 | Page value |
| addr_i | input | 16 | Starting offset (bytes or words) |
| count_i | input | 16 | Transfers minus one |
| word_mode_i | input | 1 | 1 = word mode, 0 = byte mode |
| mask_i | input | 1 | Freeze the channel |
| xfer_i | input | 1 | Transfer strobe |
| phys_addr_o | output | 24 | Physical byte address |
| byte_en_o | output | 2 | Byte lanes of a 16-bit bus |
| word_o | output | 1 | Presented transfer is a word |
| valid_o | output | 1 | An address is presented this cycle |
| tc_o | output | 1 | Terminal-count pulse |
| active_o | output | 1 | Channel armed |

## Verification
Every result depends on a strobe or load that is sampled at a rising edge, and it becomes visible right after that same edge through one register stage. Nothing takes longer than one cycle. The bench drives inputs on the falling edge and samples one time unit after the next rising edge, so each check reads the cycle that the strobe just produced. A bench-side model tracks offset, count and armed state arithmetically across a sweep of modes, page values, offsets near the wrap point, small counts and mask patterns.

// File: rtl/dma_pag_pkg.sv
package dma_pag_pkg;
  typedef enum logic {
    XW_BYTE = 1'b0,
    XW_WORD = 1'b1
  } xfer_width_e;
endpackage

// File: rtl/dma_pag_cfg.sv
module dma_pag_cfg
  import dma_pag_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              word_mode_i,
  output logic [PAGE_W-1:0] page_o,
  output xfer_width_e       width_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_o  <= '0;
      width_o <= XW_BYTE;
    end else if (load_i) begin
      page_o  <= page_i;
      width_o <= word_mode_i ? XW_WORD : XW_BYTE;
    end
  end
endmodule

// File: rtl/dma_pag_offset.sv
module dma_pag_offset #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic             step_i,
  output logic [OFS_W-1:0] offset_o
);
  localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};

  // wraps inside the offset field; page bits are never carried into
  always_ff @(posedge clk) begin
    if (rst)         offset_o <= '0;
    else if (load_i) offset_o <= addr_i;
    else if (step_i) offset_o <= offset_o + ONE;
  end
endmodule

// File: rtl/dma_pag_count.sv
module dma_pag_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             step_i,
  output logic             active_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_o <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= count_i;
      active_o <= 1'b1;
    end else if (step_i) begin
      cnt_q <= cnt_q - ONE;
      if (last_o) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_pag_fmt.sv
module dma_pag_fmt
  import dma_pag_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic              last_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  xfer_width_e       width_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic [1:0]        be_o,
  output logic              word_o,
  output logic              valid_o,
  output logic              tc_o
);
  logic [PHYS_W-1:0] byte_addr;
  logic [PHYS_W-1:0] word_addr;
  logic [PHYS_W-1:0] phys_d;
  logic [1:0]        be_d;

  assign byte_addr = {page_i, offset_i};

  generate
    if (PAGE_W > 1) begin : g_wide_page
      assign word_addr = {page_i[PAGE_W-1:1], offset_i, 1'b0};
    end else begin : g_narrow_page
      assign word_addr = {offset_i, 1'b0};
    end
  endgenerate

  always_comb begin
    if (width_i == XW_WORD) begin
      phys_d = word_addr;
      be_d   = 2'b11;
    end else begin
      phys_d = byte_addr;
      be_d   = offset_i[0] ? 2'b10 : 2'b01;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_o  <= '0;
      be_o    <= 2'b00;
      word_o  <= 1'b0;
      valid_o <= 1'b0;
      tc_o    <= 1'b0;
    end else begin
      valid_o <= fire_i;
      tc_o    <= fire_i & last_i;
      if (fire_i) begin
        phys_o <= phys_d;
        be_o   <= be_d;
        word_o <= (width_i == XW_WORD);
      end
    end
  end
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dma_pag_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [OFS_W-1:0]  count_i,
  input  logic              word_mode_i,
  input  logic              mask_i,
  input  logic              xfer_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [1:0]        byte_en_o,
  output logic              word_o,
  output logic              valid_o,
  output logic              tc_o,
  output logic              active_o
);
  logic [PAGE_W-1:0] page_q;
  xfer_width_e       width_q;
  logic [OFS_W-1:0]  offset_q;
  logic              last_w;
  logic              fire;

  // load wins over a strobe at the same edge
  assign fire = xfer_i & active_o & ~mask_i & ~load_i;

  dma_pag_cfg #(.PAGE_W(PAGE_W)) u_cfg (
    .clk(clk), .rst(rst), .load_i(load_i), .page_i(page_i),
    .word_mode_i(word_mode_i), .page_o(page_q), .width_o(width_q)
  );

  dma_pag_offset #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst(rst), .load_i(load_i), .addr_i(addr_i),
    .step_i(fire), .offset_o(offset_q)
  );

  dma_pag_count #(.CNT_W(OFS_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(load_i), .count_i(count_i),
    .step_i(fire), .active_o(active_o), .last_o(last_w)
  );

  dma_pag_fmt #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_fmt (
    .clk(clk), .rst(rst), .fire_i(fire), .last_i(last_w),
    .page_i(page_q), .offset_i(offset_q), .width_i(width_q),
    .phys_o(phys_addr_o), .be_o(byte_en_o), .word_o(word_o),
    .valid_o(valid_o), .tc_o(tc_o)
  );
endmodule

// File: rtl/dma_page_addr_gen_chk.sv
module dma_page_addr_gen_chk #(
  parameter int PHYS_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              mask_i,
  input logic              xfer_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic [1:0]        byte_en_o,
  input logic              word_o,
  input logic              valid_o,
  input logic              tc_o,
  input logic              active_o
);
  a_r3_word_even: assert property (@(posedge clk) disable iff (rst)
    (valid_o && word_o) |-> (phys_addr_o[0] == 1'b0));

  a_r5_tc_has_valid: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> valid_o);

  a_r5_tc_disarms: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> !active_o);

  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_i) && !$past(load_i)) |-> !valid_o);

  a_r7_valid_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(xfer_i) && $past(active_o)));

  a_r8_word_lanes: assert property (@(posedge clk) disable iff (rst)
    (valid_o && word_o) |-> (byte_en_o == 2'b11));

  a_r8_byte_lane_one: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !word_o) |-> ($countones(byte_en_o) == 1));

  a_r9_load_arms: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (active_o && !valid_o));
endmodule

bind dma_page_addr_gen dma_page_addr_gen_chk #(.PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .mask_i(mask_i), .xfer_i(xfer_i),
  .phys_addr_o(phys_addr_o), .byte_en_o(byte_en_o), .word_o(word_o),
  .valid_o(valid_o), .tc_o(tc_o), .active_o(active_o)
);

// File: tb/dma_page_addr_gen_test.sv
`timescale 1ns/1ps
module dma_page_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0;
  logic [7:0]  page_i = '0;
  logic [15:0] addr_i = '0;
  logic [15:0] count_i = '0;
  logic        word_mode_i = 1'b0;
  logic        mask_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic [23:0] phys_addr_o;
  logic [1:0]  byte_en_o;
  logic        word_o, valid_o, tc_o, active_o;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0]  m_page;
  logic [15:0] m_ofs, m_cnt;
  logic        m_word, m_act;

  always #2 clk = ~clk;

  dma_page_addr_gen uut (
    .clk(clk), .rst(rst), .load_i(load_i), .page_i(page_i), .addr_i(addr_i),
    .count_i(count_i), .word_mode_i(word_mode_i), .mask_i(mask_i), .xfer_i(xfer_i),
    .phys_addr_o(phys_addr_o), .byte_en_o(byte_en_o), .word_o(word_o),
    .valid_o(valid_o), .tc_o(tc_o), .active_o(active_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [7:0] pg, input logic [15:0] a,
                         input logic [15:0] c, input logic w, input logic strobe);
    @(negedge clk);
    load_i = 1'b1; page_i = pg; addr_i = a; count_i = c; word_mode_i = w;
    xfer_i = strobe; mask_i = 1'b0;
    tick();
    load_i = 1'b0; xfer_i = 1'b0;
    m_page = pg; m_ofs = a; m_cnt = c; m_word = w; m_act = 1'b1;
    chk("R9 active after load", {31'd0, active_o}, 32'd1);
    chk("R9 strobe with load ignored", {31'd0, valid_o}, 32'd0);
  endtask

  task automatic strobe(input logic m);
    logic [23:0] ea;
    logic [1:0]  eb;
    logic        acc;
    @(negedge clk);
    xfer_i = 1'b1; mask_i = m;
    tick();
    xfer_i = 1'b0; mask_i = 1'b0;
    acc = m_act && !m;
    chk("R7 valid on accepted strobe", {31'd0, valid_o}, {31'd0, acc});
    if (acc) begin
      ea = m_word ? {m_page[7:1], m_ofs, 1'b0} : {m_page, m_ofs};
      eb = m_word ? 2'b11 : (m_ofs[0] ? 2'b10 : 2'b01);
      chk(m_word ? "R3 word address" : "R2 byte address", {8'd0, phys_addr_o}, {8'd0, ea});
      chk("R8 byte enables", {30'd0, byte_en_o}, {30'd0, eb});
      chk("R8 word flag", {31'd0, word_o}, {31'd0, m_word});
      chk("R5 terminal count", {31'd0, tc_o}, {31'd0, (m_cnt == 16'h0000)});
      if (m_cnt == 16'h0000) m_act = 1'b0;
      m_ofs = m_ofs + 16'd1;   // R4 wrap within the page
      m_cnt = m_cnt - 16'd1;
    end else begin
      chk("R6 no terminal count when not accepted", {31'd0, tc_o}, 32'd0);
    end
    chk("R5 active state", {31'd0, active_o}, {31'd0, m_act});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    chk("R1 valid reset", {31'd0, valid_o}, 32'd0);
    chk("R1 tc reset", {31'd0, tc_o}, 32'd0);
    chk("R1 active reset", {31'd0, active_o}, 32'd0);
    chk("R1 word reset", {31'd0, word_o}, 32'd0);
    chk("R1 addr reset", {8'd0, phys_addr_o}, 32'd0);
    chk("R1 be reset", {30'd0, byte_en_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    m_act = 1'b0; m_page = '0; m_ofs = '0; m_cnt = '0; m_word = 1'b0;

    // strobe while idle
    strobe(1'b0);

    // sweep: modes, pages, offsets around wrap, small counts, mask patterns
    for (int w = 0; w < 2; w++) begin
      for (int p = 0; p < 4; p++) begin
        for (int o = 0; o < 4; o++) begin
          for (int c = 0; c < 4; c++) begin
            logic [7:0]  pg;
            logic [15:0] ofs;
            pg  = 8'h5A ^ (8'(p) * 8'h3B);
            ofs = 16'hFFFE - 16'(o) + ((o == 3) ? 16'h1235 : 16'h0);
            do_load(pg, ofs, 16'(c), w[0], (c == 2));
            for (int s = 0; s < c + 3; s++)
              strobe(((s + o) % 3) == 1);
          end
        end
      end
    end

    // explicit wrap check: byte mode, page kept
    do_load(8'hC3, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
    strobe(1'b0);
    strobe(1'b0);
    chk("R4 wrapped offset kept page", {8'd0, phys_addr_o}, 32'h00C30000);
    chk("R5 tc after two transfers", {31'd0, tc_o}, 32'd1);

    // word mode: page bit 0 ignored
    do_load(8'h37, 16'h0000, 16'h0000, 1'b1, 1'b0);
    strobe(1'b0);
    chk("R3 page bit 0 ignored", {8'd0, phys_addr_o}, 32'h00360000);
    strobe(1'b0);

    // re-arm after terminal count
    do_load(8'h01, 16'h0010, 16'h0000, 1'b0, 1'b0);
    strobe(1'b1);
    strobe(1'b0);
    chk("R6 masked strobe kept offset", {8'd0, phys_addr_o}, 32'h00010010);

    // long count: 300 transfers
    do_load(8'h80, 16'hFF00, 16'd299, 1'b1, 1'b0);
    for (int s = 0; s < 302; s++) strobe(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule